// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the path from a local host bus toward a PCIe-style address space. It turns each local request address into the matching remote address. It holds a small set of translation windows. Each window has a match half and a mapping half. The match half holds an enable flag, a size selector and the local base. The mapping half holds the remote base. Each half is split into a low and a high 32-bit register.

Before any window is compared, a fixed local offset is subtracted from the incoming address. The result is checked against every enabled window at once. When several windows match, the lowest-numbered one wins. Its remote base, plus the position of the address inside the window, is returned one clock later. A 32-bit register port writes and reads back the windows.

Top module: `ob_addr_xlat`

## Requirements
- R1: After reset, every window register reads zero, every window is disabled, and `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_win` and `rsp_addr` are all zero.
- R2: Window w owns byte addresses 16*w to 16*w+15 of the register port, and address bits [1:0] are ignored:
  - +0 is the match low register: bit 0 is the enable flag, bits [2:1] are the size index, and bits [31:3] are local base bits [31:3].
  - +4 is the match high register, holding local base bits [63:32].
  - +8 is the remote low register and +12 is the remote high register.
  - `reg_rdata` returns the stored value of the addressed register in the same cycle.
- R3: The window size is 128 MB shifted left by the size index. Windows flagged wide in `WIDE_MASK` (windows 2 and 3 by default) accept indexes 0 to 3, that is 128, 256, 512 or 1024 MB. The other windows accept only indexes 0 and 1, that is 128 or 256 MB. A window holding an unsupported index never hits.
- R4: The local address is `req_addr - LOCAL_OFF`. With the default offset of 0x4000_0000, a request below the offset never hits.
- R5: An enabled window hits when the local address lies in the span that starts at its local base rounded down to the window size and is one window size long. Base bits below the window size are ignored.
- R6: On a hit, `rsp_addr` is the remote base rounded down to the window size, plus the distance of the local address from the rounded local base.
- R7: When several windows hit, the lowest-numbered one is reported in `rsp_win` and supplies `rsp_addr`.
- R8: A request that hits no window gives `rsp_miss`=1, `rsp_hit`=0, `rsp_win`=0 and `rsp_addr`=0.
- R9: Results are registered. `rsp_valid`, `rsp_hit` and `rsp_miss` describe the request from the previous clock cycle. When no request was presented, all three are 0.
- R10: Writing the match low register with bit 0 clear disables that window from the next cycle on. A request presented in the cycle right after the write misses that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 64 | Local request address |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Request matched a window |
| rsp_miss | output | 1 | Request matched no window |
| rsp_win | output | 2 | Index of the winning window |
| rsp_addr | output | 64 | Translated remote address, zero on a miss |

## Verification
The bench loads four non-overlapping windows, one of each size. It sweeps addresses across each window and beyond both ends, including the first and last byte inside and the first byte on either side. This separates off-by-one range errors from size-decode errors. A second layout stacks three windows over the same span, so that only priority order decides the winner. Further patterns cover the following:
- unsupported size indexes on narrow windows, which separate the per-window size lists;
- a base and a remote value with stray low bits, which show that those bits are masked;
- addresses on either side of the local offset;
- a request issued in the cycle right after a disabling write, which pins down when the change takes effect.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;

  localparam int XA_W   = 64;
  localparam int SIDX_W = 2;

  typedef logic [XA_W-1:0] xaddr_t;

  typedef struct packed {
    logic              en;
    logic [SIDX_W-1:0] sidx;
    xaddr_t            base;
    xaddr_t            remote;
  } win_cfg_t;

  // log2 of the window size in bytes
  function automatic int unsigned win_shift(input logic [SIDX_W-1:0] sidx,
                                            input int unsigned min_shift);
    return min_shift + 32'(sidx);
  endfunction

  // ones below the window size
  function automatic xaddr_t low_mask(input int unsigned sh);
    return (xaddr_t'(1) << sh) - xaddr_t'(1);
  endfunction

  function automatic logic sidx_ok(input logic [SIDX_W-1:0] sidx,
                                   input int unsigned nsz);
    return 32'(sidx) < nsz;
  endfunction

  function automatic logic win_hit(input win_cfg_t c, input xaddr_t loc,
                                   input xaddr_t m);
    return c.en && ((loc & ~m) == (c.base & ~m));
  endfunction

  function automatic xaddr_t win_xlat(input win_cfg_t c, input xaddr_t loc,
                                      input xaddr_t m);
    return (c.remote & ~m) | (loc & m);
  endfunction

endpackage

// File: rtl/ob_win_regs.sv
module ob_win_regs
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int RA_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output win_cfg_t [NUM_WIN-1:0]   cfg
);
  localparam int SLOTS = 4;
  localparam int WS_W  = RA_W - 4;

  logic [31:0]     q [NUM_WIN][SLOTS];
  logic [WS_W-1:0] sel_win;
  logic [1:0]      sel_slot;
  logic            unused_lsb;

  assign sel_win    = reg_addr[RA_W-1:4];
  assign sel_slot   = reg_addr[3:2];
  assign unused_lsb = ^reg_addr[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q[w][s] <= '0;
        else if (reg_wr && sel_win == WS_W'(w) && sel_slot == 2'(s))
          q[w][s] <= reg_wdata;
      end
    end
    assign cfg[w].en     = q[w][0][0];
    assign cfg[w].sidx   = q[w][0][SIDX_W:1];
    assign cfg[w].base   = {q[w][1], q[w][0][31:3], 3'b000};
    assign cfg[w].remote = {q[w][3], q[w][2]};
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (sel_win == WS_W'(w)) reg_rdata = q[w][sel_slot];
  end

endmodule

// File: rtl/ob_win_match.sv
module ob_win_match
  import ob_xlat_pkg::*;
#(
  parameter int                  NUM_WIN    = 4,
  parameter int unsigned         MIN_SHIFT  = 27,
  parameter int unsigned         NSZ_NARROW = 2,
  parameter int unsigned         NSZ_WIDE   = 4,
  parameter logic [NUM_WIN-1:0]  WIDE_MASK  = 4'b1100
) (
  input  win_cfg_t [NUM_WIN-1:0] cfg,
  input  xaddr_t                 loc,
  input  logic                   in_range,
  output logic [NUM_WIN-1:0]     hit_vec,
  output xaddr_t [NUM_WIN-1:0]   xlat
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    localparam int unsigned NSZ = WIDE_MASK[w] ? NSZ_WIDE : NSZ_NARROW;
    xaddr_t m;
    logic   size_ok;
    assign m          = low_mask(win_shift(cfg[w].sidx, MIN_SHIFT));
    assign size_ok    = sidx_ok(cfg[w].sidx, NSZ);
    assign hit_vec[w] = in_range && size_ok && win_hit(cfg[w], loc, m);
    assign xlat[w]    = win_xlat(cfg[w], loc, m);
  end
endmodule

// File: rtl/ob_prio_pick.sv
module ob_prio_pick #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  output logic [NUM_WIN-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  assign grant = hit_vec & (~hit_vec + NUM_WIN'(1));
  assign any   = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (hit_vec[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/ob_addr_xlat.sv
module ob_addr_xlat
  import ob_xlat_pkg::*;
#(
  parameter int                  NUM_WIN    = 4,
  parameter logic [63:0]         LOCAL_OFF  = 64'h0000_0000_4000_0000,
  parameter int unsigned         MIN_SHIFT  = 27,
  parameter int unsigned         NSZ_NARROW = 2,
  parameter int unsigned         NSZ_WIDE   = 4,
  parameter logic [NUM_WIN-1:0]  WIDE_MASK  = 4'b1100,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int RA_W  = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [63:0]       rsp_addr
);
  win_cfg_t [NUM_WIN-1:0] cfg;
  logic     [NUM_WIN-1:0] hit_vec;
  logic     [NUM_WIN-1:0] grant_vec;
  logic     [NUM_WIN-1:0] win_en;
  xaddr_t   [NUM_WIN-1:0] xlat;
  xaddr_t                 loc;
  logic                   in_range;
  logic     [IDX_W-1:0]   pick_idx;
  logic                   any_hit;

  ob_win_regs #(.NUM_WIN(NUM_WIN), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg)
  );

  assign loc      = req_addr - LOCAL_OFF;
  assign in_range = req_addr >= LOCAL_OFF;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_en
    assign win_en[w] = cfg[w].en;
  end

  ob_win_match #(
    .NUM_WIN(NUM_WIN), .MIN_SHIFT(MIN_SHIFT), .NSZ_NARROW(NSZ_NARROW),
    .NSZ_WIDE(NSZ_WIDE), .WIDE_MASK(WIDE_MASK)
  ) u_match (
    .cfg(cfg), .loc(loc), .in_range(in_range), .hit_vec(hit_vec), .xlat(xlat)
  );

  ob_prio_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .grant(grant_vec), .idx(pick_idx), .any(any_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit;
      rsp_miss  <= req_valid && !any_hit;
      rsp_win   <= (req_valid && any_hit) ? pick_idx : '0;
      rsp_addr  <= (req_valid && any_hit) ? xlat[pick_idx] : '0;
    end
  end

endmodule

// File: rtl/ob_addr_xlat_chk.sv
module ob_addr_xlat_chk #(
  parameter int          NUM_WIN   = 4,
  parameter logic [63:0] LOCAL_OFF = 64'h0000_0000_4000_0000,
  parameter int unsigned MIN_SHIFT = 27,
  parameter int          IDX_W     = 2,
  parameter int          RA_W      = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [RA_W-1:0]    reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               req_valid,
  input logic [63:0]        req_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic [IDX_W-1:0]   rsp_win,
  input logic [63:0]        rsp_addr,
  input logic [NUM_WIN-1:0] hit_vec,
  input logic [NUM_WIN-1:0] grant_vec,
  input logic [NUM_WIN-1:0] win_en
);
  localparam logic [63:0] LOWM = (64'd1 << MIN_SHIFT) - 64'd1;

  // R9
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_addr == 64'd0 && rsp_win == '0 && !rsp_hit));

  // R4
  below_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ($past(req_addr) >= LOCAL_OFF));

  // R6
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (((rsp_addr ^ ($past(req_addr) - LOCAL_OFF)) & LOWM) == 64'd0));

  // R5
  hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ($past(win_en) != '0));

  // R7
  lowest_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && (((grant_vec - NUM_WIN'(1)) & hit_vec) == '0)
    && ((|hit_vec) == (|grant_vec)));

  // R10
  disable_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[3:2] == 2'd0 && !reg_wdata[0])
    |=> !win_en[$past(reg_addr[RA_W-1:4])]);

endmodule

bind ob_addr_xlat ob_addr_xlat_chk #(
  .NUM_WIN(NUM_WIN), .LOCAL_OFF(LOCAL_OFF), .MIN_SHIFT(MIN_SHIFT),
  .IDX_W(IDX_W), .RA_W(RA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_win(rsp_win), .rsp_addr(rsp_addr), .hit_vec(hit_vec),
  .grant_vec(grant_vec), .win_en(win_en)
);

// File: tb/ob_addr_xlat_bench.sv
module ob_addr_xlat_bench;
  localparam int          NW   = 4;
  localparam logic [63:0] OFF  = 64'h0000_0000_4000_0000;
  localparam logic [3:0]  WIDE = 4'b1100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [1:0]  rsp_win;
  logic [63:0] rsp_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] mirror [NW][4];

  always #5 clk = ~clk;

  ob_addr_xlat u_ob_addr_xlat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // arithmetic model: division-based alignment, lowest index wins
  task automatic model(input logic [63:0] a, output logic hit, output int win,
                       output logic [63:0] xa);
    hit = 1'b0; win = 0; xa = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      logic [63:0] base, rem, sz, loc, bs;
      int n, idx;
      n    = WIDE[w] ? 4 : 2;
      idx  = int'((mirror[w][0] >> 1) & 32'd3);
      base = {mirror[w][1], mirror[w][0] & 32'hFFFF_FFF8};
      rem  = {mirror[w][3], mirror[w][2]};
      sz   = 64'd134217728 * (64'd1 << idx);
      if (mirror[w][0][0] && idx < n && a >= OFF) begin
        loc = a - OFF;
        bs  = base - (base % sz);
        if (loc >= bs && (loc - bs) < sz) begin
          hit = 1'b1; win = w; xa = (rem - (rem % sz)) + (loc - bs);
        end
      end
    end
  endtask

  task automatic wr(input int w, input int k, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(w * 16 + k * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    mirror[w][k] = d;
  endtask

  task automatic rd_chk(input int w, input int k, input string tag);
    @(negedge clk);
    reg_addr = 6'(w * 16 + k * 4 + 1);
    #1;
    chk(tag, {32'd0, reg_rdata}, {32'd0, mirror[w][k]});
  endtask

  task automatic check_rsp(input logic [63:0] a, input string tag);
    logic eh; int ew; logic [63:0] ea;
    model(a, eh, ew, ea);
    chk({tag, " valid (R9)"}, {63'd0, rsp_valid}, 64'd1);
    chk({tag, " hit"}, {63'd0, rsp_hit}, {63'd0, eh});
    chk({tag, " miss (R8)"}, {63'd0, rsp_miss}, {63'd0, !eh});
    chk({tag, " win (R7)"}, {62'd0, rsp_win}, 64'(ew));
    chk({tag, " addr (R6)"}, rsp_addr, ea);
  endtask

  task automatic lookup(input logic [63:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(a, tag);
  endtask

  task automatic sweep(input int w, input string tag);
    logic [63:0] base, sz, bs; int idx;
    idx  = int'((mirror[w][0] >> 1) & 32'd3);
    sz   = 64'd134217728 << idx;
    base = {mirror[w][1], mirror[w][0] & 32'hFFFF_FFF8};
    bs   = base - (base % sz);
    lookup(OFF + bs - 64'd1, tag);
    lookup(OFF + bs, tag);
    lookup(OFF + bs + sz - 64'd1, tag);
    lookup(OFF + bs + sz, tag);
    for (int j = 0; j < 12; j++)
      lookup(OFF + bs - sz / 2 + 64'(j) * (sz / 8) + 64'h123, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 4; k++) mirror[w][k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 rsp_hit", {63'd0, rsp_hit}, 64'd0);
    chk("R1 rsp_miss", {63'd0, rsp_miss}, 64'd0);
    chk("R1 rsp_addr", rsp_addr, 64'd0);
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 4; k++) rd_chk(w, k, "R1 reg zero");
    lookup(OFF, "R1 empty lookup");

    // R2: readback of every register, then clear
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 4; k++) wr(w, k, 32'hA5C3_0000 ^ 32'(w * 16 + k * 4) ^ (32'h1 << (k * 7 + w)));
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 4; k++) rd_chk(w, k, "R2 readback");
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 4; k++) wr(w, k, 32'd0);

    // layout A: disjoint windows, one per size
    wr(0, 1, 32'h0); wr(0, 2, 32'h0);         wr(0, 3, 32'h1);  wr(0, 0, 32'h0800_0001);
    wr(1, 1, 32'h0); wr(1, 2, 32'h9000_0000); wr(1, 3, 32'h2);  wr(1, 0, 32'h2000_0003);
    wr(2, 1, 32'h1); wr(2, 2, 32'hC000_0000); wr(2, 3, 32'h40); wr(2, 0, 32'h0000_0007);
    wr(3, 1, 32'h0); wr(3, 2, 32'h6000_0000); wr(3, 3, 32'h5);  wr(3, 0, 32'h4000_0005);
    rd_chk(2, 0, "R2 match low");
    rd_chk(2, 3, "R2 remote high");
    sweep(0, "R3 R5 128MB");
    sweep(1, "R3 R5 256MB");
    sweep(2, "R3 R5 1GB");
    sweep(3, "R3 R5 512MB");

    // R4: offset boundary
    lookup(64'd0, "R4 zero addr");
    lookup(OFF + 64'h0800_0000 - OFF - 64'd1, "R4 under offset");

    // layout B: stacked windows, priority decides
    wr(1, 0, 32'h0000_0003);
    wr(3, 0, 32'h0000_0005);
    sweep(0, "R7 stacked");
    lookup(OFF - 64'd1, "R4 below offset");
    lookup(OFF, "R4 at offset");

    // R3: unsupported size indexes on narrow windows
    wr(0, 0, 32'h0800_0005);
    wr(1, 0, 32'h0000_0007);
    lookup(OFF + 64'h0800_0000, "R3 narrow idx2");
    lookup(OFF + 64'h0000_1000, "R3 narrow idx3");
    lookup(OFF + 64'h2000_0000, "R3 upper span");

    // R5/R6: stray low bits in base and remote
    wr(2, 0, 32'h1234_5677);
    wr(2, 2, 32'hC123_4560);
    lookup(OFF + 64'h1_0000_0000, "R5 unaligned base lo");
    lookup(OFF + 64'h1_3FFF_FFFF, "R5 unaligned base hi");
    lookup(OFF + 64'h1_2345_6788, "R6 unaligned remote");

    // R10: disable, request in the very next cycle
    lookup(OFF + 64'h1_0000_0040, "R10 before disable");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'd32; reg_wdata = 32'h1234_5676;
    @(negedge clk);
    reg_wr = 1'b0; mirror[2][0] = 32'h1234_5676;
    req_valid = 1'b1; req_addr = OFF + 64'h1_0000_0040;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 miss next cycle", {63'd0, rsp_miss}, 64'd1);
    check_rsp(OFF + 64'h1_0000_0040, "R10 disabled");
    rd_chk(2, 0, "R10 readback");

    // R9: idle cycle after a request
    @(negedge clk);
    chk("R9 idle valid", {63'd0, rsp_valid}, 64'd0);
    chk("R9 idle hit", {63'd0, rsp_hit}, 64'd0);
    chk("R9 idle miss", {63'd0, rsp_miss}, 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule